// File: doc/BRIEF.md
# Audio Converter Clock Generator

This block produces the three clocks an external audio converter needs when the converter is a timing slave. The three clocks are a master clock, a bit clock and a word-select clock. All three come from one 12 MHz system clock and hold fixed ratios to each other. The master clock runs at 1.024 MHz. The bit clock is the master clock divided by 4, which gives 256 kHz. The word-select clock is the master clock divided by 256, which gives the 4 kHz sample rate with one left slot and one right slot per period.

There is no integer divide from 12 MHz to 1.024 MHz, so the master clock is the top bit of a phase accumulator. Its average frequency is exact, and each edge can be off by up to one system cycle. A single frame counter advances on every falling edge of the master clock and drives the bit clock and the word-select clock. Because of this, both slower clocks move only on master-clock falling edges. The block also gives a one-cycle strobe when word select toggles, for a serializer further along the chain. An enable input clears the whole chain. When enable goes high again, the chain restarts from a known phase.

Top module: `audio_clkgen`

## Requirements
- R1: The master clock output is the top bit of a 24-bit accumulator. The accumulator starts at 0 when enable is set and adds 1431656 on every system cycle while enabled. Counting the enabling edge as edge 1, the master clock first goes high after the 6th edge. Exactly 256 master-clock falling edges occur in the first 3000 enabled cycles.
- R2: After the first master-clock rise, every high phase and every low phase of the master clock lasts 5 or 6 system cycles.
- R3: The bit clock changes only in a cycle in which the master clock falls, and it changes on every second such fall. It first rises on the 2nd master-clock fall after enable, so its period is 4 master-clock periods.
- R4: The word-select clock changes only in a cycle in which the bit clock falls, and it changes on every 32nd such fall. It is low (left slot) from enable until its first rise, which comes on the 128th master-clock fall.
- R5: The word-select strobe is high for exactly one system cycle, and only in the cycle in which the word-select clock changes level.
- R6: When enable is sampled low, all four outputs are low in the next cycle and stay low while enable is low. This holds even if the clocks were high at that moment. On re-enable, the sequence of R1, R3 and R4 restarts from its beginning.
- R7: While reset is asserted, all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low clears the divider chain |
| mclk_o | output | 1 | Converter master clock, 1.024 MHz average |
| sclk_o | output | 1 | Bit clock, 1/4 of the master clock |
| lrck_o | output | 1 | Word-select clock, low = left slot, 1/256 of the master clock |
| lr_edge_o | output | 1 | One-cycle strobe in the cycle the word-select clock toggles |

## Verification
On every cycle, the assertions check the following:
- each master-clock phase stays within its 5-to-6-cycle bound;
- the bit clock moves only on a master-clock fall;
- word select moves only on a bit-clock fall;
- the strobe matches a word-select change and is never wider than one cycle;
- the outputs drop one cycle after enable goes low.

Only the bench scenarios can show the absolute counts. These are: where the first master-clock rise falls, that exactly 256 master periods fit in 3000 cycles, the divide-by-2 spacing of bit-clock changes and the divide-by-32 spacing of word-select changes, the left-first order, and that a disable taken with every clock high leads to the same restart sequence.

// File: rtl/audio_clkgen_pkg.sv
package audio_clkgen_pkg;

    // Output bundle shared by the top level
    typedef struct packed {
        logic mclk;
        logic sclk;
        logic lrck;
        logic lr_edge;
    } clk_bundle_t;

    // Rounded accumulator increment for a target rate
    function automatic longint nco_step(longint sys_hz, longint tgt_hz, int acc_w);
        return ((tgt_hz << acc_w) + (sys_hz / 2)) / sys_hz;
    endfunction

endpackage

// File: rtl/audio_clk_nco.sv
module audio_clk_nco
    import audio_clkgen_pkg::*;
#(
    parameter longint SYS_HZ  = 12_000_000,
    parameter longint MCLK_HZ = 1_024_000,
    parameter int     ACC_W   = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic mclk_o,
    output logic fall_o
);
    localparam longint           STEP_L = nco_step(SYS_HZ, MCLK_HZ, ACC_W);
    localparam logic [ACC_W-1:0] STEP   = STEP_L[ACC_W-1:0];
    localparam int               MSB    = ACC_W - 1;
    localparam longint           PH_MIN = (longint'(1) << MSB) / STEP_L;
    localparam longint           PH_MAX = PH_MIN + 1;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } nco_st_t;

    nco_st_t st_d, st_q;
    logic    fall_d;

    always_comb begin
        st_d   = st_q;
        fall_d = 1'b0;
        if (!en) begin
            st_d.acc = '0;
        end else begin
            st_d.acc = st_q.acc + STEP;
            fall_d   = st_q.acc[MSB] && !st_d.acc[MSB];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mclk_o = st_q.acc[MSB];
    assign fall_o = fall_d;

    // Phase-length tracker for the checks below
    logic [7:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             run_q <= '0;
        else if (!en)                           run_q <= '0;
        else if (st_d.acc[MSB] != st_q.acc[MSB]) run_q <= 8'd1;
        else if (run_q != 8'hFF)                run_q <= run_q + 8'd1;
    end

    AST_MCLK_PHASE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        longint'(run_q) <= PH_MAX);                                        // R2
    AST_MCLK_PHASE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (en && run_q != 8'd0 && st_d.acc[MSB] != st_q.acc[MSB])
        |-> longint'(run_q) >= PH_MIN);                                    // R2

endmodule

// File: rtl/audio_clk_frame_div.sv
module audio_clk_frame_div #(
    parameter int MCLK_PER_BIT   = 4,
    parameter int BITS_PER_FRAME = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic mclk_fall_i,
    output logic sclk_o,
    output logic lrck_o,
    output logic lr_edge_o
);
    localparam int FRAME      = MCLK_PER_BIT * BITS_PER_FRAME;
    localparam int CW         = $clog2(FRAME);
    localparam int HALF_BIT   = MCLK_PER_BIT / 2;
    localparam int HALF_FRAME = FRAME / 2;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          sclk;
        logic          lrck;
        logic          lr_edge;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d = '0;
        end else begin
            st_d.lr_edge = 1'b0;
            if (mclk_fall_i) begin
                st_d.lr_edge = (st_q.cnt == CW'(HALF_FRAME - 1)) ||
                               (st_q.cnt == CW'(FRAME - 1));
                st_d.cnt     = (st_q.cnt == CW'(FRAME - 1)) ? '0 : st_q.cnt + CW'(1);
            end
            st_d.sclk = (st_d.cnt % CW'(MCLK_PER_BIT)) >= CW'(HALF_BIT);
            st_d.lrck = st_d.cnt >= CW'(HALF_FRAME);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sclk_o    = st_q.sclk;
    assign lrck_o    = st_q.lrck;
    assign lr_edge_o = st_q.lr_edge;

    AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !mclk_fall_i) |=> ($stable(sclk_o) && $stable(lrck_o)));    // R3

endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
    import audio_clkgen_pkg::*;
#(
    parameter longint SYS_HZ         = 12_000_000,
    parameter longint MCLK_HZ        = 1_024_000,
    parameter int     ACC_W          = 24,
    parameter int     MCLK_PER_BIT   = 4,
    parameter int     BITS_PER_FRAME = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic mclk_o,
    output logic sclk_o,
    output logic lrck_o,
    output logic lr_edge_o
);
    clk_bundle_t bus;
    logic        mclk_fall;

    audio_clk_nco #(
        .SYS_HZ (SYS_HZ),
        .MCLK_HZ(MCLK_HZ),
        .ACC_W  (ACC_W)
    ) u_nco (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .mclk_o(bus.mclk),
        .fall_o(mclk_fall)
    );

    audio_clk_frame_div #(
        .MCLK_PER_BIT  (MCLK_PER_BIT),
        .BITS_PER_FRAME(BITS_PER_FRAME)
    ) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .mclk_fall_i(mclk_fall),
        .sclk_o     (bus.sclk),
        .lrck_o     (bus.lrck),
        .lr_edge_o  (bus.lr_edge)
    );

    assign mclk_o    = bus.mclk;
    assign sclk_o    = bus.sclk;
    assign lrck_o    = bus.lrck;
    assign lr_edge_o = bus.lr_edge;

    AST_SCLK_ON_MCLK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && sclk_o != $past(sclk_o)) |-> (!mclk_o && $past(mclk_o)));   // R3
    AST_LRCK_ON_SCLK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && lrck_o != $past(lrck_o)) |-> (!sclk_o && $past(sclk_o)));   // R4
    AST_EDGE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en) |-> (lr_edge_o == (lrck_o != $past(lrck_o))));                  // R5
    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        lr_edge_o |=> !lr_edge_o);                                                // R5
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!mclk_o && !sclk_o && !lrck_o && !lr_edge_o));                   // R6

endmodule

// File: tb/tb_audio_clkgen.sv
module tb_audio_clkgen;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic mclk_o, sclk_o, lrck_o, lr_edge_o;

    always #2 clk = ~clk;

    audio_clkgen dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .mclk_o   (mclk_o),
        .sclk_o   (sclk_o),
        .lrck_o   (lrck_o),
        .lr_edge_o(lr_edge_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    task automatic check_eq(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int outs();
        return {28'd0, mclk_o, sclk_o, lrck_o, lr_edge_o};
    endfunction

    // Run enabled for n samples from a cleared state and check the sequence
    task automatic run_seq(string tag, int n, int exp_falls, int exp_lr);
        int first_rise = 0, mfalls = 0, nchg = 0, run = 0, phase_bad = 0;
        int s_bad = 0, s_gap_bad = 0, s_tog = 0, mf_since = 0;
        int l_bad = 0, l_gap_bad = 0, l_tog = 0, sf_since = 0, l_first = -1;
        int e_bad = 0, e_cnt = 0;
        logic pm = 1'b0, ps = 1'b0, pl = 1'b0;
        en = 1'b1;
        for (int s = 1; s <= n; s++) begin
            logic mf, sf;
            @(negedge clk);
            mf = pm && !mclk_o;
            sf = ps && !sclk_o;
            if (!pm && mclk_o && first_rise == 0) first_rise = s;
            if (mf) begin mfalls++; mf_since++; end
            if (mclk_o != pm) begin
                if (nchg > 0 && (run < 5 || run > 6)) phase_bad++;
                nchg++;
                run = 1;
            end else run++;
            if (sclk_o != ps) begin
                s_tog++;
                if (!mf) s_bad++;
                if (mf_since != 2) s_gap_bad++;
                mf_since = 0;
            end
            if (sf) sf_since++;
            if (lrck_o != pl) begin
                l_tog++;
                if (l_first < 0) l_first = int'(lrck_o);
                if (!sf) l_bad++;
                if (sf_since != 32) l_gap_bad++;
                sf_since = 0;
            end
            if (lr_edge_o != (lrck_o != pl)) e_bad++;
            if (lr_edge_o) e_cnt++;
            pm = mclk_o; ps = sclk_o; pl = lrck_o;
        end
        check_eq({"R1 first mclk rise sample ", tag}, first_rise, 6);
        check_eq({"R1 mclk falls in window ", tag}, mfalls, exp_falls);
        check_eq({"R2 mclk phase out of 5..6 ", tag}, phase_bad, 0);
        check_eq({"R3 sclk change off mclk fall ", tag}, s_bad, 0);
        check_eq({"R3 sclk spacing not 2 falls ", tag}, s_gap_bad, 0);
        check_eq({"R3 sclk toggle count ", tag}, s_tog, exp_falls / 2);
        check_eq({"R4 lrck change off sclk fall ", tag}, l_bad, 0);
        check_eq({"R4 lrck spacing not 32 sclk falls ", tag}, l_gap_bad, 0);
        check_eq({"R4 lrck toggle count ", tag}, l_tog, exp_lr);
        check_eq({"R4 lrck first change is rise ", tag}, l_first, 1);
        check_eq({"R5 strobe mismatch ", tag}, e_bad, 0);
        check_eq({"R5 strobe count ", tag}, e_cnt, exp_lr);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check_eq("R7 outputs in reset", outs(), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_idle();
        int bad = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (outs() != 0) bad++;
        end
        check_eq("R6 outputs while disabled", bad, 0);
    endtask

    task automatic t_main();
        run_seq("main", 3000, 256, 2);
    endtask

    task automatic t_disable_restart();
        int bad = 0;
        while (!(mclk_o && sclk_o && lrck_o)) @(negedge clk);
        check_eq("R6 all clocks high before disable", outs() >> 1, 7);
        en = 1'b0;
        @(negedge clk);
        check_eq("R6 outputs one cycle after disable", outs(), 0);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (outs() != 0) bad++;
        end
        check_eq("R6 outputs held low", bad, 0);
        run_seq("restart R6", 1600, 136, 1);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
            summary();
            $finish;
        end
    end

    initial begin
        t_reset();
        t_idle();
        t_main();
        t_disable_restart();
        done = 1'b1;
        summary();
        $finish;
    end
endmodule